// File: doc/BRIEF.md
# DMA Transfer Length and Completion Tracker

This block sizes and tracks one information-transfer command of a SCSI initiator controller. Software writes a transfer count as two halves and pulses a reload strobe, which copies them into the readable count. When a transfer starts, the block works out the number of bytes for this DMA window. It takes the smaller of the programmed count and a limit. In command phase the limit is a fixed 32-byte cap. Otherwise it is the magnitude of the signed remaining device length, whose sign gives the direction. The block then counts the window down, one byte for each acknowledged DMA beat.

When the window is used up, the block either finishes at once or waits. It finishes at once in command phase, or when the device still holds more read data than the window took. In every other case it waits for the device layer to report done. On finishing it sets the terminal-count status, records a bus-service interrupt cause, zeroes the flags and the readable count, and emits a one-cycle interrupt strobe. A separate status-response strobe, accepted only while idle, posts the status-phase completion.

Top module: `xfer_len_tracker`

## Requirements
- R1: After reset, cnt_rd, remain, flags_val, dma_req, xfer_busy, tc_flag, st_flag, intr_bs, intr_fc and intr_pulse are all zero.
- R2: A reload pulse while idle makes cnt_rd equal {cnt_hi_in, cnt_lo_in} on the next cycle. A reload pulse while busy leaves cnt_rd unchanged.
- R3: On start, the effective length is min(N, L). N is cnt_rd, with zero meaning 65536. L is 32 when cmd_phase is 1. Otherwise L is -dev_len when dev_len is negative, with to_dev set to 1, and dev_len when it is not negative, with to_dev set to 0.
- R4: A start while idle with a nonzero effective length loads remain with it and sets xfer_busy. It also clears tc_flag, st_flag, intr_bs and intr_fc. A start while busy has no effect on remain.
- R5: dma_req is 1 exactly when a transfer is running with remain nonzero and dev_avail is 1. Each cycle with dma_req and beat_ack both at 1 lowers remain by one.
- R6: On completion, tc_flag=1, intr_bs=1, intr_fc=0, flags_val=0, cnt_rd=0, remain=0 and xfer_busy=0, and intr_pulse is 1 for exactly one cycle.
- R7: When the last beat is acknowledged, completion happens on that same edge in two cases: cmd_phase was 1 at start, or dev_len was positive and larger than N. In every other case the block holds xfer_busy with dma_req at 0 until dev_done, and completes on the dev_done edge.
- R8: A start with an effective length of zero completes on the start edge.
- R9: A status_rsp pulse while idle (and without start) sets tc_flag=1, st_flag=1, intr_bs=1, intr_fc=1 and flags_val=2, and gives a one-cycle intr_pulse. While busy it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_lo_in | input | CNT_W/2 | Host-written low half of the transfer count |
| cnt_hi_in | input | CNT_W/2 | Host-written high half of the transfer count |
| reload | input | 1 | Copy the written halves into cnt_rd |
| start | input | 1 | Begin a transfer-information command |
| dev_len | input | DEV_W | Signed remaining device length; negative means toward the device |
| cmd_phase | input | 1 | Transfer carries command bytes |
| dev_avail | input | 1 | Device data buffer ready for beats |
| beat_ack | input | 1 | One byte moved by DMA this cycle |
| dev_done | input | 1 | Device layer reports the chunk finished |
| status_rsp | input | 1 | Post a status-phase response |
| cnt_rd | output | CNT_W | Readable transfer count |
| remain | output | CNT_W+1 | Bytes left in the current window |
| dma_req | output | 1 | DMA request |
| to_dev | output | 1 | Direction of the running transfer |
| xfer_busy | output | 1 | A transfer is running or awaiting device done |
| tc_flag | output | 1 | Terminal-count status bit |
| st_flag | output | 1 | Status-phase status bit |
| intr_bs | output | 1 | Bus-service interrupt cause |
| intr_fc | output | 1 | Function-complete interrupt cause |
| flags_val | output | FLAGS_W | Flags register value |
| intr_pulse | output | 1 | One-cycle interrupt raise strobe |

## Verification
The bench builds the block with its defaults: CNT_W of 16, DEV_W of 24 and a 32-byte command cap. With a 16-bit count, the zero-means-65536 case fits in one full-speed pass. With a 24-bit device length, a device can hold more bytes than any window, so both the immediate and the deferred completion paths are exercised. Random transfers use lengths of a few hundred bytes with gaps in both availability and acknowledge. Directed cases cover the cap, an equal count and device length, a zero-length window and negative lengths.

// File: rtl/xlt_pkg.sv
// Shared types for the transfer length tracker.
// Assumes nothing beyond the parameters of the top.
package xlt_pkg;
    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_RUN  = 2'd1,
        XS_WAIT = 2'd2
    } xlt_state_e;

    localparam int FLAGS_ON_STATUS = 2;
endpackage

// File: rtl/xlt_len_calc.sv
// Effective window length: min of the programmed count (zero = 2**CNT_W)
// and the limit, which is CMD_CAP in command phase or |dev_len| otherwise.
// Also reports direction and whether the device holds more than the count.
// Purely combinational; assumes dev_len is two's complement.
module xlt_len_calc #(
    parameter int CNT_W   = 16,
    parameter int DEV_W   = 24,
    parameter int CMD_CAP = 32
) (
    input  logic [CNT_W-1:0]        prog_cnt,
    input  logic signed [DEV_W-1:0] dev_len,
    input  logic                    cmd,
    output logic [CNT_W:0]          eff_len,
    output logic                    dir_out,
    output logic                    more_dev
);
    localparam int MW = (DEV_W > CNT_W + 1) ? DEV_W : CNT_W + 1;

    logic [DEV_W-1:0] mag_raw;
    logic [MW-1:0]    full_cnt;
    logic [MW-1:0]    mag;
    logic [MW-1:0]    lim;
    logic [MW-1:0]    pick;

    // Compute magnitudes, the limit and the minimum.
    always_comb begin
        mag_raw  = dev_len[DEV_W-1] ? DEV_W'(-dev_len) : DEV_W'(dev_len);
        mag      = MW'(mag_raw);
        full_cnt = (prog_cnt == '0) ? (MW'(1) << CNT_W) : MW'(prog_cnt);
        lim      = cmd ? MW'(CMD_CAP) : mag;
        pick     = (full_cnt < lim) ? full_cnt : lim;
        eff_len  = (CNT_W+1)'(pick);
        dir_out  = !cmd && dev_len[DEV_W-1];
        more_dev = !cmd && !dev_len[DEV_W-1] && (mag > full_cnt);
    end
endmodule

// File: rtl/xlt_window.sv
// Window down-counter: loads the effective length and drops by one per
// accepted beat. Assumes dec is only raised while the count is nonzero.
module xlt_window #(
    parameter int CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [CNT_W:0] load_val,
    input  logic           dec,
    output logic [CNT_W:0] remain,
    output logic           last
);
    // Hold, load or decrement the remaining byte count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (dec && remain != '0)
            remain <= remain - 1'b1;
    end

    assign last = (remain == (CNT_W+1)'(1));

    p_dec_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && remain != '0) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/xlt_status.sv
// Status, interrupt cause and flags holding registers. Start clears the
// status and cause bits; completion and status response set them.
// Assumes the three strobes are mutually exclusive.
module xlt_status #(
    parameter int FLAGS_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_start,
    input  logic               complete,
    input  logic               stat_post,
    output logic               tc_flag,
    output logic               st_flag,
    output logic               intr_bs,
    output logic               intr_fc,
    output logic [FLAGS_W-1:0] flags_val,
    output logic               intr_pulse
);
    import xlt_pkg::*;

    // Update status bits, causes and flags on each event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_flag    <= 1'b0;
            st_flag    <= 1'b0;
            intr_bs    <= 1'b0;
            intr_fc    <= 1'b0;
            flags_val  <= '0;
            intr_pulse <= 1'b0;
        end else begin
            intr_pulse <= complete || stat_post;
            if (complete) begin
                tc_flag   <= 1'b1;
                intr_bs   <= 1'b1;
                intr_fc   <= 1'b0;
                flags_val <= '0;
            end else if (stat_post) begin
                tc_flag   <= 1'b1;
                st_flag   <= 1'b1;
                intr_bs   <= 1'b1;
                intr_fc   <= 1'b1;
                flags_val <= FLAGS_W'(FLAGS_ON_STATUS);
            end else if (clr_start) begin
                tc_flag   <= 1'b0;
                st_flag   <= 1'b0;
                intr_bs   <= 1'b0;
                intr_fc   <= 1'b0;
            end
        end
    end

    p_done_sets_tc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (tc_flag && intr_bs && !intr_fc && intr_pulse));
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_pulse && !complete && !stat_post) |=> !intr_pulse);
    p_start_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_start && !complete) |=> !tc_flag);
endmodule

// File: rtl/xlt_len_tracker.sv
// Top: information-transfer length tracker. Holds the readable count,
// sizes each window, runs the beat counter and decides between immediate
// and device-deferred completion. Assumes start, reload and status_rsp
// are single-cycle pulses from the register front end.
module xfer_len_tracker #(
    parameter int CNT_W   = 16,
    parameter int DEV_W   = 24,
    parameter int CMD_CAP = 32,
    parameter int FLAGS_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W/2-1:0]      cnt_lo_in,
    input  logic [CNT_W/2-1:0]      cnt_hi_in,
    input  logic                    reload,
    input  logic                    start,
    input  logic signed [DEV_W-1:0] dev_len,
    input  logic                    cmd_phase,
    input  logic                    dev_avail,
    input  logic                    beat_ack,
    input  logic                    dev_done,
    input  logic                    status_rsp,
    output logic [CNT_W-1:0]        cnt_rd,
    output logic [CNT_W:0]          remain,
    output logic                    dma_req,
    output logic                    to_dev,
    output logic                    xfer_busy,
    output logic                    tc_flag,
    output logic                    st_flag,
    output logic                    intr_bs,
    output logic                    intr_fc,
    output logic [FLAGS_W-1:0]      flags_val,
    output logic                    intr_pulse
);
    import xlt_pkg::*;

    xlt_state_e     state;
    logic           imm_q;
    logic [CNT_W:0] eff_len;
    logic           dir_now;
    logic           more_dev;
    logic           idle;
    logic           go;
    logic           go_zero;
    logic           beat_ok;
    logic           last;
    logic           complete;
    logic           stat_post;

    xlt_len_calc #(.CNT_W(CNT_W), .DEV_W(DEV_W), .CMD_CAP(CMD_CAP)) u_calc (
        .prog_cnt (cnt_rd),
        .dev_len  (dev_len),
        .cmd      (cmd_phase),
        .eff_len  (eff_len),
        .dir_out  (dir_now),
        .more_dev (more_dev)
    );

    // Decode the events of this cycle.
    always_comb begin
        idle      = (state == XS_IDLE);
        go        = idle && start;
        go_zero   = go && (eff_len == '0);
        beat_ok   = dma_req && beat_ack;
        complete  = go_zero
                 || (beat_ok && last && imm_q)
                 || ((state == XS_WAIT) && dev_done);
        stat_post = idle && status_rsp && !start;
    end

    assign dma_req   = (state == XS_RUN) && dev_avail;
    assign xfer_busy = !idle;

    xlt_window #(.CNT_W(CNT_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go),
        .load_val (eff_len),
        .dec      (beat_ok),
        .remain   (remain),
        .last     (last)
    );

    xlt_status #(.FLAGS_W(FLAGS_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_start  (go),
        .complete   (complete),
        .stat_post  (stat_post),
        .tc_flag    (tc_flag),
        .st_flag    (st_flag),
        .intr_bs    (intr_bs),
        .intr_fc    (intr_fc),
        .flags_val  (flags_val),
        .intr_pulse (intr_pulse)
    );

    // Transfer state: idle, counting beats, or waiting for device done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= XS_IDLE;
            imm_q  <= 1'b0;
            to_dev <= 1'b0;
        end else begin
            case (state)
                XS_IDLE: if (go && !go_zero) begin
                    state  <= XS_RUN;
                    imm_q  <= cmd_phase || more_dev;
                    to_dev <= dir_now;
                end
                XS_RUN: if (beat_ok && last)
                    state <= imm_q ? XS_IDLE : XS_WAIT;
                XS_WAIT: if (dev_done)
                    state <= XS_IDLE;
                default: state <= XS_IDLE;
            endcase
        end
    end

    // Readable count: reload while idle, zeroed by completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_rd <= '0;
        else if (complete)
            cnt_rd <= '0;
        else if (reload && idle)
            cnt_rd <= {cnt_hi_in, cnt_lo_in};
    end

    p_reload_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !idle) |=> (cnt_rd == $past(cnt_rd) || cnt_rd == '0));
    p_run_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == XS_RUN) |-> (remain != '0));
    p_wait_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == XS_WAIT) |-> (!dma_req && remain == '0));
    p_zero_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        go_zero |=> (!xfer_busy && intr_pulse));
    p_status_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rsp && !idle && !complete) |=> !st_flag);
endmodule

// File: tb/tb_xfer_len_tracker.sv
module tb_xfer_len_tracker;
    localparam int CNT_W = 16;
    localparam int DEV_W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] cnt_lo_in = '0, cnt_hi_in = '0;
    logic reload = 0, start = 0, cmd_phase = 0, dev_avail = 0;
    logic beat_ack = 0, dev_done = 0, status_rsp = 0;
    logic signed [DEV_W-1:0] dev_len = '0;
    logic [CNT_W-1:0] cnt_rd;
    logic [CNT_W:0] remain;
    logic dma_req, to_dev, xfer_busy, tc_flag, st_flag, intr_bs, intr_fc;
    logic [4:0] flags_val;
    logic intr_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    xfer_len_tracker dut (
        .clk(clk), .rst_n(rst_n), .cnt_lo_in(cnt_lo_in), .cnt_hi_in(cnt_hi_in),
        .reload(reload), .start(start), .dev_len(dev_len), .cmd_phase(cmd_phase),
        .dev_avail(dev_avail), .beat_ack(beat_ack), .dev_done(dev_done),
        .status_rsp(status_rsp), .cnt_rd(cnt_rd), .remain(remain),
        .dma_req(dma_req), .to_dev(to_dev), .xfer_busy(xfer_busy),
        .tc_flag(tc_flag), .st_flag(st_flag), .intr_bs(intr_bs),
        .intr_fc(intr_fc), .flags_val(flags_val), .intr_pulse(intr_pulse)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_eff(input int cnt, input int dl, input bit cmd);
        int full, lim;
        full = (cnt == 0) ? 65536 : cnt;
        lim  = cmd ? 32 : ((dl < 0) ? -dl : dl);
        return (full < lim) ? full : lim;
    endfunction

    function automatic bit exp_imm(input int cnt, input int dl, input bit cmd);
        int full;
        full = (cnt == 0) ? 65536 : cnt;
        return cmd || (dl > 0 && dl > full);
    endfunction

    task automatic check_done(input string tag);
        check({tag, " R6 intr_pulse"}, int'(intr_pulse), 1);
        check({tag, " R6 busy"}, int'(xfer_busy), 0);
        check({tag, " R6 tc"}, int'(tc_flag), 1);
        check({tag, " R6 bs"}, int'(intr_bs), 1);
        check({tag, " R6 fc"}, int'(intr_fc), 0);
        check({tag, " R6 flags"}, int'(flags_val), 0);
        check({tag, " R6 cnt_rd"}, int'(cnt_rd), 0);
        check({tag, " R6 remain"}, int'(remain), 0);
        step();
        check({tag, " R6 pulse one cycle"}, int'(intr_pulse), 0);
    endtask

    task automatic run_xfer(input int cnt, input int dl, input bit cmd);
        int eff, n, guard;
        bit fast, av, ak;
        cnt_lo_in = cnt[7:0];
        cnt_hi_in = cnt[15:8];
        reload = 1;
        step();
        reload = 0;
        check("R2 reload idle", int'(cnt_rd), cnt);
        eff = exp_eff(cnt, dl, cmd);
        dev_len = DEV_W'(dl);
        cmd_phase = cmd;
        start = 1;
        step();
        start = 0;
        if (eff == 0) begin
            check("R8 zero window done", int'(intr_pulse), 1);
            check_done("R8");
            return;
        end
        check("R4 busy", int'(xfer_busy), 1);
        check("R3 effective length", int'(remain), eff);
        check("R3 direction", int'(to_dev), int'(!cmd && dl < 0));
        check("R4 tc cleared", int'(tc_flag), 0);
        // Busy-time strobes must have no effect.
        cnt_lo_in = ~cnt[7:0];
        cnt_hi_in = 8'h5a;
        reload = 1; start = 1; status_rsp = 1;
        step();
        reload = 0; start = 0; status_rsp = 0;
        check("R2 reload ignored busy", int'(cnt_rd), cnt);
        check("R4 start ignored busy", int'(remain), eff);
        check("R9 status ignored busy", int'(st_flag), 0);
        check("R9 no pulse busy", int'(intr_pulse), 0);
        fast = (eff > 200);
        n = 0;
        guard = 0;
        while (n < eff && guard < 150000) begin
            av = fast ? 1'b1 : ($urandom % 4 != 0);
            ak = fast ? 1'b1 : ($urandom % 3 != 0);
            dev_avail = av;
            beat_ack = ak;
            #1;
            if (!fast) check("R5 dma_req", int'(dma_req), int'(av));
            step();
            guard++;
            if (av && ak) n++;
            if (!fast && n < eff) check("R5 remain", int'(remain), eff - n);
        end
        beat_ack = 0;
        if (exp_imm(cnt, dl, cmd)) begin
            check("R7 immediate", int'(intr_pulse), 1);
            dev_avail = 0;
            check_done("R7");
        end else begin
            check("R7 deferred busy", int'(xfer_busy), 1);
            check("R7 deferred pulse", int'(intr_pulse), 0);
            dev_avail = 1;
            #1;
            check("R7 deferred no req", int'(dma_req), 0);
            step();
            step();
            check("R7 still waiting", int'(xfer_busy), 1);
            dev_avail = 0;
            dev_done = 1;
            step();
            dev_done = 0;
            check_done("R7");
        end
    endtask

    initial begin
        int wd = 0;
        while (!finished) begin
            @(posedge clk);
            wd++;
            if (wd > 190000 && !finished) begin
                finished = 1;
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected < 190000 cycles", wd);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        step();
        check("R1 cnt_rd", int'(cnt_rd), 0);
        check("R1 remain", int'(remain), 0);
        check("R1 dma_req", int'(dma_req), 0);
        check("R1 busy", int'(xfer_busy), 0);
        check("R1 tc", int'(tc_flag), 0);
        check("R1 st", int'(st_flag), 0);
        check("R1 causes", int'({intr_bs, intr_fc}), 0);
        check("R1 flags", int'(flags_val), 0);
        check("R1 pulse", int'(intr_pulse), 0);
        rst_n = 1;
        step();
        status_rsp = 1;
        step();
        status_rsp = 0;
        check("R9 pulse", int'(intr_pulse), 1);
        check("R9 tc st", int'({tc_flag, st_flag}), 3);
        check("R9 bs fc", int'({intr_bs, intr_fc}), 3);
        check("R9 flags", int'(flags_val), 2);
        step();
        check("R9 pulse one cycle", int'(intr_pulse), 0);
        run_xfer(100, 0, 1);
        check("R4 st cleared by start", int'(st_flag), 0);
        run_xfer(5, 7, 1);
        run_xfer(300, 10, 0);
        run_xfer(20, 1000, 0);
        run_xfer(80, -50, 0);
        run_xfer(5, 5, 0);
        run_xfer(9, 0, 0);
        run_xfer(0, -70000, 0);
        for (int i = 0; i < 30; i++) begin
            int c, d;
            c = int'($urandom % 256) + ((($urandom % 2) == 1) ? 256 : 0);
            if (i == 7) c = 0;
            d = int'($urandom % 1201) - 600;
            run_xfer(c, d, ($urandom % 4) == 0);
        end
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule